// File: doc/BRIEF.md
# Configuration Port Unlock Decoder

This block sits between a host byte bus and a group of logical devices inside a multi-function I/O controller. The host sees two byte addresses: an index port at the base and a data port at base+1. The base is picked by a strap input from two fixed values. Until the host writes the key byte 0x87 to the index port twice in a row, the configuration space stays closed. While closed, data writes are dropped and reads return 0xFF. Writing the exit byte 0xAA to the index port closes it again.

Once open, an index-port write stores the index, and every data-port access then targets that index until the next index write. A small global space is decoded here: a logical-device-number register at index 0x07 and a read-only identifier at index 0x20. Indices 0x30 and above are passed on to the logical device that the stored number selects. The devices use a plain register-file interface with a one-hot select, an address, write data, a write strobe and one read byte per device. A device keeps its own registers, such as its activate bit at index 0x30 bit 0, and returns the stored value so that software can do read-modify-write.

The unlock state machine has three states. `ST_LOCKED` is the reset state. An index write of 0x87 moves it to `ST_KEY1`; any other access leaves it in place. From `ST_KEY1`, a second index write of 0x87 moves it to `ST_OPEN`. Any other access from `ST_KEY1` (another index byte, a data write, or a read of either port) returns it to `ST_LOCKED`. From `ST_OPEN`, an index write of 0xAA returns it to `ST_LOCKED`; every other access keeps it in `ST_OPEN`. Idle cycles never change the state.

Top module: `cfgp_port`

## Requirements
- R1: The index port is at the base and the data port at base+1. The base is 0x2E when `base_sel` is 0 and 0x4E when it is 1. Accesses to any other address have no effect.
- R2: `cfg_open` rises in the cycle after the clock edge that takes the second of two consecutive index-port writes of 0x87.
- R3: After one 0x87, any access other than a second index write of 0x87 returns the block to fully locked, and two fresh 0x87 writes are then needed.
- R4: An index-port write of 0xAA while open drops `cfg_open` in the next cycle.
- R5: While locked, data-port writes reach no register and never raise `dev_we`. Reads of either port return 0xFF.
- R6: While open, an index-port write stores the index, an index-port read returns it, and data-port accesses use it until the next index write.
- R7: Index 0x07 is the logical-device-number register. It resets to 0x00, is written and read through the data port, and keeps its value across lock and unlock.
- R8: Index 0x20 reads the `CHIP_ID` parameter (default 0xA3). Writes to it are ignored.
- R9: For an index of 0x30 or above, `dev_sel` is one-hot on the bit given by the device number, `dev_addr` carries the index, `dev_we` pulses in the cycle of a data write, and a data read returns that device's byte. A device number of `NUM_DEV` (default 10) or more selects nothing, reads 0x00 and raises no `dev_we`.
- R10: Global indices below 0x30, other than 0x07 and 0x20, read 0x00 and ignore writes.
- R11: `host_rdata` takes the read result at the clock edge of a read strobe and holds it until the next read.
- R12: When `host_wr` and `host_rd` are high in the same cycle, only the write takes effect and `host_rdata` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 1 | Base address select: 0 for 0x2E, 1 for 0x4E |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| cfg_open | output | 1 | High while configuration access is unlocked |
| dev_sel | output | NUM_DEV | One-hot logical device select |
| dev_addr | output | 8 | Register index passed to devices |
| dev_wdata | output | 8 | Write byte passed to devices |
| dev_we | output | 1 | Device write strobe |
| dev_rdata | input | NUM_DEV*8 | Read byte of each device, device 0 in the low byte |

## Verification
Outputs fall into three timing classes. `cfg_open` and `host_rdata` are registered, so each is due one clock edge after the strobe that causes it. The bench drives every access on a falling edge, removes it on the next falling edge, and samples these outputs at that second falling edge. `dev_sel`, `dev_addr` and `dev_we` follow the host strobe in the same cycle, so the bench samples them one nanosecond after driving, before the rising edge. Device writes are checked one access later by reading back through the data port.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_KEY1   = 2'd1,
        ST_OPEN   = 2'd2
    } unlock_state_t;

    typedef struct packed {
        logic idx_wr;
        logic idx_rd;
        logic dat_wr;
        logic dat_rd;
    } port_access_t;

    localparam logic [7:0] KEY_BYTE      = 8'h87;
    localparam logic [7:0] EXIT_BYTE     = 8'hAA;
    localparam logic [7:0] IDX_DEVNUM    = 8'h07;
    localparam logic [7:0] IDX_IDENT     = 8'h20;
    localparam logic [7:0] IDX_BANK_BASE = 8'h30;
    localparam logic [7:0] LOCKED_READ   = 8'hFF;

endpackage

// File: rtl/cfgp_addr_dec.sv
module cfgp_addr_dec
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE_A = 16'h002E,
    parameter logic [15:0] BASE_B = 16'h004E
) (
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    output port_access_t      acc
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_A);
    localparam logic [ADDR_W-1:0] IDX_B = ADDR_W'(BASE_B);

    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;
    logic              hit_idx;
    logic              hit_dat;
    logic              rd_only;

    always_comb begin
        idx_addr = base_sel ? IDX_B : IDX_A;
        dat_addr = idx_addr + ADDR_W'(1);
        hit_idx  = (host_addr == idx_addr);
        hit_dat  = (host_addr == dat_addr);
        // a write wins over a simultaneous read
        rd_only  = host_rd & ~host_wr;
        acc.idx_wr = hit_idx & host_wr;
        acc.dat_wr = hit_dat & host_wr;
        acc.idx_rd = hit_idx & rd_only;
        acc.dat_rd = hit_dat & rd_only;
    end
endmodule

// File: rtl/cfgp_unlock_fsm.sv
module cfgp_unlock_fsm
    import cfgp_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  port_access_t acc,
    input  logic [7:0]   wdata,
    output logic         cfg_open
);
    unlock_state_t state_q;
    unlock_state_t state_d;
    logic          key_wr;
    logic          any_acc;

    always_comb begin
        key_wr  = acc.idx_wr && (wdata == KEY_BYTE);
        any_acc = acc.idx_wr | acc.idx_rd | acc.dat_wr | acc.dat_rd;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (key_wr) state_d = ST_KEY1;
            ST_KEY1: begin
                if (key_wr)       state_d = ST_OPEN;
                else if (any_acc) state_d = ST_LOCKED;
            end
            ST_OPEN: if (acc.idx_wr && (wdata == EXIT_BYTE)) state_d = ST_LOCKED;
            default: state_d = ST_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cfg_open = (state_q == ST_OPEN);
    end

    // R2: opening is always caused by a key write in the previous cycle
    assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(acc.idx_wr && (wdata == KEY_BYTE)));

    // R3: a broken sequence falls back to fully locked
    assert_broken_key_relocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY1 && (acc.dat_wr || acc.dat_rd || acc.idx_rd ||
         (acc.idx_wr && wdata != KEY_BYTE))) |=> (state_q == ST_LOCKED));

    // R4: the exit byte closes the port
    assert_exit_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && acc.idx_wr && wdata == EXIT_BYTE) |=> !cfg_open);
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter int         NUM_DEV = 10,
    parameter logic [7:0] CHIP_ID = 8'hA3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  port_access_t         acc,
    input  logic                 cfg_open,
    input  logic [7:0]           wdata,
    input  logic [NUM_DEV*8-1:0] dev_rdata,
    output logic [7:0]           host_rdata,
    output logic [NUM_DEV-1:0]   dev_sel,
    output logic [7:0]           dev_addr,
    output logic [7:0]           dev_wdata,
    output logic                 dev_we
);
    localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

    logic [7:0] idx_q;
    logic [7:0] devnum_q;
    logic       in_bank;
    logic       devnum_ok;
    logic [7:0] bank_rd;
    logic [7:0] rd_next;

    always_comb begin
        in_bank   = (idx_q >= IDX_BANK_BASE);
        devnum_ok = (devnum_q < DEV_LIMIT);
    end

    // index latch and device number register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= 8'h00;
            devnum_q <= 8'h00;
        end else if (cfg_open) begin
            if (acc.idx_wr)
                idx_q <= wdata;
            if (acc.dat_wr && idx_q == IDX_DEVNUM)
                devnum_q <= wdata;
        end
    end

    // bank select, one line per device
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
        assign dev_sel[g] = cfg_open && in_bank && (devnum_q == 8'(g));
    end

    always_comb begin
        bank_rd = 8'h00;
        for (int i = 0; i < NUM_DEV; i++)
            bank_rd |= dev_rdata[i*8 +: 8] & {8{dev_sel[i]}};
    end

    always_comb begin
        dev_addr  = idx_q;
        dev_wdata = wdata;
        dev_we    = cfg_open && acc.dat_wr && in_bank && devnum_ok;
    end

    // read multiplexer
    always_comb begin
        if (!cfg_open)        rd_next = LOCKED_READ;
        else if (acc.idx_rd)  rd_next = idx_q;
        else if (in_bank)     rd_next = bank_rd;
        else if (idx_q == IDX_DEVNUM) rd_next = devnum_q;
        else if (idx_q == IDX_IDENT)  rd_next = CHIP_ID;
        else                  rd_next = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      host_rdata <= 8'h00;
        else if (acc.idx_rd || acc.dat_rd) host_rdata <= rd_next;
    end

    // R9: at most one device selected, exactly one on a device write
    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));
    assert_we_has_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> ($countones(dev_sel) == 1));

    // R5: locked reads return all ones
    assert_locked_read_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc.dat_rd || acc.idx_rd) && !cfg_open) |=> (host_rdata == LOCKED_READ));

    // R7: device number changes only by an open data write at its index
    assert_devnum_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_open && acc.dat_wr && idx_q == IDX_DEVNUM) |=> $stable(devnum_q));

    // R11: read data holds when no read strobe
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc.idx_rd || acc.dat_rd) |=> $stable(host_rdata));
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] BASE_A  = 16'h002E,
    parameter logic [15:0] BASE_B  = 16'h004E,
    parameter int          NUM_DEV = 10,
    parameter logic [7:0]  CHIP_ID = 8'hA3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_sel,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic                 cfg_open,
    output logic [NUM_DEV-1:0]   dev_sel,
    output logic [7:0]           dev_addr,
    output logic [7:0]           dev_wdata,
    output logic                 dev_we,
    input  logic [NUM_DEV*8-1:0] dev_rdata
);
    port_access_t acc;

    cfgp_addr_dec #(
        .ADDR_W (ADDR_W),
        .BASE_A (BASE_A),
        .BASE_B (BASE_B)
    ) u_dec (
        .base_sel  (base_sel),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .acc       (acc)
    );

    cfgp_unlock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (host_wdata),
        .cfg_open (cfg_open)
    );

    cfgp_regs #(
        .NUM_DEV (NUM_DEV),
        .CHIP_ID (CHIP_ID)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .cfg_open   (cfg_open),
        .wdata      (host_wdata),
        .dev_rdata  (dev_rdata),
        .host_rdata (host_rdata),
        .dev_sel    (dev_sel),
        .dev_addr   (dev_addr),
        .dev_wdata  (dev_wdata),
        .dev_we     (dev_we)
    );

    // R5: no device write while locked
    assert_locked_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> !dev_we);
endmodule

// File: tb/sim_cfgp_port.sv
module sim_cfgp_port;
    localparam int NUM_DEV = 10;
    localparam logic [7:0] CHIP_ID = 8'hA3;

    logic                 clk = 0;
    logic                 rst_n = 0;
    logic                 base_sel = 0;
    logic [15:0]          host_addr = 0;
    logic                 host_wr = 0;
    logic                 host_rd = 0;
    logic [7:0]           host_wdata = 0;
    logic [7:0]           host_rdata;
    logic                 cfg_open;
    logic [NUM_DEV-1:0]   dev_sel;
    logic [7:0]           dev_addr;
    logic [7:0]           dev_wdata;
    logic                 dev_we;
    logic [NUM_DEV*8-1:0] dev_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int we_cnt  = 0;
    logic                 seen_we;
    logic [NUM_DEV-1:0]   seen_sel;
    logic [7:0]           seen_addr;

    always #4 clk = ~clk;

    cfgp_port #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) u0 (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .cfg_open(cfg_open), .dev_sel(dev_sel),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_we(dev_we),
        .dev_rdata(dev_rdata)
    );

    // simple device register model: 16 bytes per device from index 0x30
    logic [7:0] dmem [NUM_DEV][16];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DEV; i++)
                for (int j = 0; j < 16; j++) dmem[i][j] <= 8'h00;
        end else begin
            if (dev_we) we_cnt <= we_cnt + 1;
            for (int i = 0; i < NUM_DEV; i++)
                if (dev_we && dev_sel[i]) dmem[i][dev_addr[3:0]] <= dev_wdata;
        end
    end
    always_comb
        for (int i = 0; i < NUM_DEV; i++) dev_rdata[i*8 +: 8] = dmem[i][dev_addr[3:0]];

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ibase();
        return base_sel ? 16'h004E : 16'h002E;
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1;
        #1;
        seen_we = dev_we; seen_sel = dev_sel; seen_addr = dev_addr;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        d = host_rdata;
    endtask

    task automatic unlock();
        wr(ibase(), 8'h87);
        wr(ibase(), 8'h87);
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        wr(ibase(), idx);
        wr(ibase() + 1, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
        wr(ibase(), idx);
        rd(ibase() + 1, d);
    endtask

    task automatic t_reset();
        chk("R7 reset cfg_open", {7'd0, cfg_open}, 8'h00);
        chk("R11 reset host_rdata", host_rdata, 8'h00);
    endtask

    task automatic t_locked();
        logic [7:0] d;
        int w0 = we_cnt;
        wr(16'h002F, 8'h55);
        chk("R5 locked write no dev_we", {7'd0, seen_we}, 8'h00);
        rd(16'h002F, d);
        chk("R5 locked data read", d, 8'hFF);
        rd(16'h002E, d);
        chk("R5 locked index read", d, 8'hFF);
        chk("R5 locked write count", 8'(we_cnt - w0), 8'h00);
    endtask

    task automatic t_wrong_base();
        wr(16'h004E, 8'h87);
        wr(16'h004E, 8'h87);
        @(negedge clk);
        chk("R1 other base ignored", {7'd0, cfg_open}, 8'h00);
        wr(16'h0030, 8'h87);
        wr(16'h0030, 8'h87);
        chk("R1 stray address ignored", {7'd0, cfg_open}, 8'h00);
    endtask

    task automatic t_unlock();
        wr(16'h002E, 8'h87);
        chk("R2 one key not open", {7'd0, cfg_open}, 8'h00);
        wr(16'h002E, 8'h87);
        chk("R2 two keys open", {7'd0, cfg_open}, 8'h01);
    endtask

    task automatic t_devnum_and_id();
        logic [7:0] d;
        reg_rd(8'h07, d);
        chk("R7 devnum reset 0", d, 8'h00);
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h07, d);
        chk("R7 devnum readback", d, 8'h03);
        reg_rd(8'h20, d);
        chk("R8 chip id", d, CHIP_ID);
        wr(16'h002F, 8'h00);
        rd(16'h002F, d);
        chk("R8 id write ignored", d, CHIP_ID);
        wr(16'h002E, 8'h5C);
        rd(16'h002E, d);
        chk("R6 index readback", d, 8'h5C);
    endtask

    task automatic t_unimpl();
        logic [7:0] d;
        reg_wr(8'h25, 8'h5A);
        rd(16'h002F, d);
        chk("R10 unimplemented reads 0", d, 8'h00);
        reg_rd(8'h07, d);
        chk("R10 write did not reach devnum", d, 8'h03);
    endtask

    task automatic t_bank();
        logic [7:0] d;
        int w0;
        wr(16'h002E, 8'h30);
        wr(16'h002F, 8'h01);
        chk("R9 dev_we pulse", {7'd0, seen_we}, 8'h01);
        chk("R9 dev_sel bit 3", seen_sel[7:0], 8'h08);
        chk("R9 dev_addr", seen_addr, 8'h30);
        rd(16'h002F, d);
        chk("R9 activate readback", d, 8'h01);
        wr(16'h002F, d | 8'h04);
        rd(16'h002F, d);
        chk("R6 rmw same index", d, 8'h05);
        reg_wr(8'h07, 8'h05);
        reg_rd(8'h30, d);
        chk("R9 other device fresh", d, 8'h00);
        reg_wr(8'h07, 8'h0C);
        w0 = we_cnt;
        reg_wr(8'h30, 8'h77);
        chk("R9 out of range no we", 8'(we_cnt - w0), 8'h00);
        rd(16'h002F, d);
        chk("R9 out of range reads 0", d, 8'h00);
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h30, d);
        chk("R9 device 3 kept", d, 8'h05);
    endtask

    task automatic t_timing_prio();
        logic [7:0] d;
        reg_rd(8'h20, d);
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", host_rdata, CHIP_ID);
        wr(16'h002E, 8'h07);
        @(negedge clk);
        host_addr = 16'h002F; host_wdata = 8'h04; host_wr = 1; host_rd = 1;
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        chk("R12 read suppressed", host_rdata, CHIP_ID);
        rd(16'h002F, d);
        chk("R12 write applied", d, 8'h04);
    endtask

    task automatic t_exit_and_break();
        logic [7:0] d;
        wr(16'h002E, 8'hAA);
        chk("R4 exit closes", {7'd0, cfg_open}, 8'h00);
        wr(16'h002F, 8'h09);
        wr(16'h002E, 8'h87);
        wr(16'h002E, 8'h12);
        wr(16'h002E, 8'h87);
        chk("R3 other index byte breaks", {7'd0, cfg_open}, 8'h00);
        wr(16'h002E, 8'hAA);
        wr(16'h002E, 8'h87);
        rd(16'h002F, d);
        wr(16'h002E, 8'h87);
        chk("R3 data read breaks", {7'd0, cfg_open}, 8'h00);
        wr(16'h002E, 8'h87);
        chk("R3 fresh pair reopens", {7'd0, cfg_open}, 8'h01);
        reg_rd(8'h07, d);
        chk("R7 devnum kept over lock", d, 8'h04);
        wr(16'h002E, 8'hAA);
        base_sel = 1;
        wr(16'h002E, 8'h87);
        wr(16'h002E, 8'h87);
        chk("R1 old base dead", {7'd0, cfg_open}, 8'h00);
        wr(16'h004E, 8'h87);
        wr(16'h004E, 8'h87);
        chk("R1 alternate base opens", {7'd0, cfg_open}, 8'h01);
        reg_rd(8'h20, d);
        chk("R1 alternate data port", d, CHIP_ID);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_wrong_base();
        t_unlock();
        t_devnum_and_id();
        t_unimpl();
        t_bank();
        t_timing_prio();
        t_exit_and_break();
        summary();
    end
endmodule